// File: doc/BRIEF.md
# Prefetch Outcome Statistics Unit

This block collects runtime statistics on prefetch outcomes. The prefetch queue sends it single-cycle event pulses, and so does the cache controller. These cover a request being generated, issued, filled, found late, cancelled by the coherence logic, or dropped because the queue overflowed. The cache also reports load hits and evictions with the index of the line involved. Seven saturating counters keep the totals. Software, or a debug port, reads them through a combinational register read port. A synchronous clear zeroes them all.

A line whose prefetch fill completes is marked inside the block, in a table that holds one bit per line. The first load hit on a marked line scores it as useful and removes the mark. An eviction of a line that is still marked scores it as unuseful. For latency, the block stores the local cycle count in a slot per outstanding tag when the request is issued. On the fill with that tag it adds the elapsed cycles to a wide saturating accumulator.

Top module: `pf_stats_top`

## Requirements
- R1: Each cycle with `gen_i` high adds one to the total counter, read at address 0.
- R2: Each cycle with `fill_i` high adds one to the completed counter, read at address 1, and marks line `fill_line_i`.
- R3: A load hit (`hit_i`) on a marked line adds one to the useful counter (address 2) and clears the mark, so further hits on that line add nothing.
- R4: An eviction (`evict_i`) of a marked line adds one to the unuseful counter (address 3) and clears the mark. Hits and evictions of unmarked lines change no counter.
- R5: `late_i`, `cancel_i` and `ovf_i` each add one to their own counter, at addresses 4, 5 and 6 respectively.
- R6: On a fill, the accumulator adds the number of clock cycles from the `issue_i` pulse for that tag to the fill, modulo 2^TS_W. Its low CNT_W bits read at address 7 and its remaining upper bits read at address 8.
- R7: A counter that holds all ones stays at all ones on further increments.
- R8: When an addition would overflow the accumulator, it sticks at all ones.
- R9: `clr_i` zeroes every counter and the accumulator in the next cycle. This takes priority over any increment in the same cycle.
- R10: When a hit and an eviction name the same marked line in one cycle, the event counts as useful only.
- R11: After reset every address reads zero, and addresses 9 to 15 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of counters and accumulator |
| gen_i | input | 1 | Prefetch generated |
| issue_i | input | 1 | Prefetch issued to the hierarchy |
| issue_tag_i | input | TAG_W | Tag of the issued request |
| fill_i | input | 1 | Prefetch fill completed |
| fill_tag_i | input | TAG_W | Tag of the completed request |
| fill_line_i | input | LINE_W | Cache line filled by the prefetch |
| late_i | input | 1 | Prefetch found late |
| cancel_i | input | 1 | Prefetch cancelled by coherence logic |
| ovf_i | input | 1 | Prefetch dropped on queue overflow |
| hit_i | input | 1 | Load hit |
| hit_line_i | input | LINE_W | Line index of the load hit |
| evict_i | input | 1 | Line eviction |
| evict_line_i | input | LINE_W | Line index of the eviction |
| rd_addr_i | input | 4 | Read register select |
| rd_data_o | output | CNT_W | Selected register value |

## Verification
Clearing and counting can fall in the same cycle. A clear is raised together with a generate pulse, and the bench checks that every address then reads zero. A hit and an eviction can also name the same marked line in one cycle. That case is provoked directly, and the bench checks that only the useful counter moves. The random phase raises all event inputs independently, including rare clears, and compares every register against a bench model that applies these same priorities.

// File: rtl/pf_stats_pkg.sv
// Package: shared constants and register-select encoding for the prefetch
// statistics unit. Assumes counter indices match read addresses 0..6.
package pf_stats_pkg;
    localparam int N_CNT = 7;

    typedef enum logic [3:0] {
        SEL_TOTAL    = 4'd0,
        SEL_DONE     = 4'd1,
        SEL_USEFUL   = 4'd2,
        SEL_WASTED   = 4'd3,
        SEL_LATE     = 4'd4,
        SEL_CANCEL   = 4'd5,
        SEL_OVERFLOW = 4'd6,
        SEL_LAT_LO   = 4'd7,
        SEL_LAT_HI   = 4'd8
    } stat_sel_e;
endpackage

// File: rtl/pf_sat_cnt.sv
// Module: saturating event counter with synchronous clear.
// Assumes inc_i is a single-cycle pulse per event; clear beats increment.
module pf_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Count events, hold at all ones, zero on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cnt_o <= '0;
        else if (inc_i && cnt_o != MAXV)
            cnt_o <= cnt_o + W'(1);
    end

    AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == MAXV && !clr_i) |=> cnt_o == MAXV); // R7
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_o == '0); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && cnt_o != MAXV) |=> cnt_o == $past(cnt_o) + W'(1)); // R1
endmodule

// File: rtl/pf_line_marks.sv
// Module: per-line "filled by prefetch, not yet used" mark table.
// Produces useful / unuseful pulses. Assumes NUM_LINES is a power of two.
// A fill sets a mark; a hit or eviction clears it; a fill wins over a
// clear on the same line in the same cycle.
module pf_line_marks #(
    parameter int NUM_LINES = 64,
    localparam int LINE_W = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_i,
    input  logic [LINE_W-1:0] fill_line_i,
    input  logic              hit_i,
    input  logic [LINE_W-1:0] hit_line_i,
    input  logic              evict_i,
    input  logic [LINE_W-1:0] evict_line_i,
    output logic              useful_o,
    output logic              unuseful_o
);
    logic [NUM_LINES-1:0] mark_q;
    logic                 same_line;

    // Score outcomes; a same-line hit in the same cycle takes the line.
    always_comb begin
        same_line  = hit_i && (hit_line_i == evict_line_i);
        useful_o   = hit_i && mark_q[hit_line_i];
        unuseful_o = evict_i && mark_q[evict_line_i] && !same_line;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_mark
        // Set on fill, clear on first hit or eviction of this line.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mark_q[g] <= 1'b0;
            else if (fill_i && fill_line_i == LINE_W'(g))
                mark_q[g] <= 1'b1;
            else if ((hit_i && hit_line_i == LINE_W'(g)) ||
                     (evict_i && evict_line_i == LINE_W'(g)))
                mark_q[g] <= 1'b0;
        end
    end

    AST_SAME_LINE_USEFUL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && evict_i && hit_line_i == evict_line_i) |-> !unuseful_o); // R10
    AST_USEFUL_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        useful_o |-> hit_i); // R3
    AST_USEFUL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (useful_o && !(fill_i && fill_line_i == hit_line_i))
        |=> !(useful_o && hit_line_i == $past(hit_line_i))); // R3
endmodule

// File: rtl/pf_latency.sv
// Module: issue-to-fill latency accumulator. Records a local cycle stamp
// per tag on issue and adds (now - stamp) mod 2^TS_W to a saturating sum
// on fill. Assumes ACC_W >= TS_W and NUM_TAGS a power of two.
module pf_latency #(
    parameter int NUM_TAGS = 16,
    parameter int TS_W     = 16,
    parameter int ACC_W    = 48,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             issue_i,
    input  logic [TAG_W-1:0] issue_tag_i,
    input  logic             fill_i,
    input  logic [TAG_W-1:0] fill_tag_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

    logic [TS_W-1:0]  now_q;
    logic [TS_W-1:0]  stamp_q [NUM_TAGS];
    logic [TS_W-1:0]  delta;
    logic [ACC_W:0]   sum;

    // Free-running local time base.
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + TS_W'(1);
    end

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_stamp
        // Capture the issue time of this tag.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stamp_q[t] <= '0;
            else if (issue_i && issue_tag_i == TAG_W'(t))
                stamp_q[t] <= now_q;
        end
    end

    // Elapsed time and widened sum for the overflow test.
    always_comb begin
        delta = now_q - stamp_q[fill_tag_i];
        sum   = {1'b0, acc_o} + (ACC_W + 1)'(delta);
    end

    // Accumulate on fill, stick at all ones, clear beats add.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            acc_o <= '0;
        else if (fill_i)
            acc_o <= sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
    end

    AST_ACC_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> acc_o >= $past(acc_o)); // R6
    AST_ACC_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o == ACC_MAX && !clr_i) |=> acc_o == ACC_MAX); // R8
    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> acc_o == '0); // R9
endmodule

// File: rtl/pf_stats_top.sv
// Module: prefetch outcome statistics unit. Seven saturating counters,
// a per-line usefulness mark table and an issue-to-fill latency sum,
// read through a combinational register port. Assumes ACC_W <= 2*CNT_W
// so the accumulator fits in two read addresses.
module pf_stats_top
    import pf_stats_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int ACC_W     = 48,
    parameter int TS_W      = 16,
    parameter int NUM_TAGS  = 16,
    parameter int NUM_LINES = 64,
    localparam int TAG_W    = $clog2(NUM_TAGS),
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              gen_i,
    input  logic              issue_i,
    input  logic [TAG_W-1:0]  issue_tag_i,
    input  logic              fill_i,
    input  logic [TAG_W-1:0]  fill_tag_i,
    input  logic [LINE_W-1:0] fill_line_i,
    input  logic              late_i,
    input  logic              cancel_i,
    input  logic              ovf_i,
    input  logic              hit_i,
    input  logic [LINE_W-1:0] hit_line_i,
    input  logic              evict_i,
    input  logic [LINE_W-1:0] evict_line_i,
    input  logic [3:0]        rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o
);
    logic             useful, unuseful;
    logic [N_CNT-1:0] inc;
    logic [CNT_W-1:0] cnt [N_CNT];
    logic [ACC_W-1:0] acc;

    pf_line_marks #(.NUM_LINES(NUM_LINES)) i_marks (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_i       (fill_i),
        .fill_line_i  (fill_line_i),
        .hit_i        (hit_i),
        .hit_line_i   (hit_line_i),
        .evict_i      (evict_i),
        .evict_line_i (evict_line_i),
        .useful_o     (useful),
        .unuseful_o   (unuseful)
    );

    pf_latency #(.NUM_TAGS(NUM_TAGS), .TS_W(TS_W), .ACC_W(ACC_W)) i_lat (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .issue_i     (issue_i),
        .issue_tag_i (issue_tag_i),
        .fill_i      (fill_i),
        .fill_tag_i  (fill_tag_i),
        .acc_o       (acc)
    );

    // Route each event to its counter slot (slot = read address).
    always_comb begin
        inc               = '0;
        inc[SEL_TOTAL]    = gen_i;
        inc[SEL_DONE]     = fill_i;
        inc[SEL_USEFUL]   = useful;
        inc[SEL_WASTED]   = unuseful;
        inc[SEL_LATE]     = late_i;
        inc[SEL_CANCEL]   = cancel_i;
        inc[SEL_OVERFLOW] = ovf_i;
    end

    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        pf_sat_cnt #(.W(CNT_W)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_i),
            .inc_i (inc[k]),
            .cnt_o (cnt[k])
        );
    end

    // Register read mux; unmapped addresses return zero.
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i < 4'(N_CNT))
            rd_data_o = cnt[rd_addr_i[2:0]];
        else if (rd_addr_i == SEL_LAT_LO)
            rd_data_o = acc[CNT_W-1:0];
        else if (rd_addr_i == SEL_LAT_HI)
            rd_data_o = CNT_W'(acc >> CNT_W);
    end

    AST_DONE_TRACKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !clr_i && cnt[SEL_DONE] != {CNT_W{1'b1}})
        |=> cnt[SEL_DONE] != '0); // R2
endmodule

// File: tb/test_pf_stats_top.sv
`timescale 1ns/1ps
module test_pf_stats_top;
    localparam int CW = 6, AW = 10, TW = 8, NT = 4, NL = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic clr, gen, iss, fil, lat, can, ovf, hit, evc;
    logic [1:0] itag, ftag;
    logic [3:0] fline, hline, eline, raddr;
    logic [CW-1:0] rdata;

    int n_chk = 0, n_bad = 0, step = 0;
    int m_cnt [7];
    int m_acc;
    bit m_mark [NL];
    int m_ts [NT];
    bit m_iss [NT];

    always #2 clk = ~clk;

    pf_stats_top #(.CNT_W(CW), .ACC_W(AW), .TS_W(TW), .NUM_TAGS(NT), .NUM_LINES(NL)) i_pf_stats_top (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .gen_i(gen), .issue_i(iss),
        .issue_tag_i(itag), .fill_i(fil), .fill_tag_i(ftag), .fill_line_i(fline),
        .late_i(lat), .cancel_i(can), .ovf_i(ovf), .hit_i(hit), .hit_line_i(hline),
        .evict_i(evc), .evict_line_i(eline), .rd_addr_i(raddr), .rd_data_o(rdata));

    function automatic int sat(input int v, input int mx);
        return (v > mx) ? mx : v;
    endfunction

    function automatic int expect_at(input int a);
        if (a < 7)  return m_cnt[a];
        if (a == 7) return m_acc % 64;
        if (a == 8) return m_acc / 64;
        return 0;
    endfunction

    task automatic idle_inputs();
        {clr, gen, iss, fil, lat, can, ovf, hit, evc} = '0;
        itag = 0; ftag = 0; fline = 0; hline = 0; eline = 0;
    endtask

    // Bench model of one clock edge, applied from the requirement rules.
    task automatic model_edge();
        int u, w, d;
        u = (hit && m_mark[hline]) ? 1 : 0;
        w = (evc && m_mark[eline] && !(hit && hline == eline)) ? 1 : 0;
        d = (step - m_ts[ftag]) & 255;
        if (clr) begin
            foreach (m_cnt[k]) m_cnt[k] = 0;
            m_acc = 0;
        end else begin
            m_cnt[0] = sat(m_cnt[0] + int'(gen), 63);
            m_cnt[1] = sat(m_cnt[1] + int'(fil), 63);
            m_cnt[2] = sat(m_cnt[2] + u, 63);
            m_cnt[3] = sat(m_cnt[3] + w, 63);
            m_cnt[4] = sat(m_cnt[4] + int'(lat), 63);
            m_cnt[5] = sat(m_cnt[5] + int'(can), 63);
            m_cnt[6] = sat(m_cnt[6] + int'(ovf), 63);
            if (fil) m_acc = sat(m_acc + d, 1023);
        end
        if (hit) m_mark[hline] = 0;
        if (evc) m_mark[eline] = 0;
        if (fil) m_mark[fline] = 1;
        if (iss) begin m_ts[itag] = step; m_iss[itag] = 1; end
        step++;
    endtask

    // Inputs already driven at a negedge; take one edge, return at negedge.
    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic check_one(input int a, input int exp, input string req);
        raddr = 4'(a);
        #0.1;
        n_chk++;
        if (int'(rdata) != exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%0d expected=%0d", req, a, rdata, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 10; a++) check_one(a, expect_at(a), req);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        foreach (m_cnt[k]) m_cnt[k] = 0;
        m_acc = 0;
        foreach (m_mark[k]) m_mark[k] = 0;
        foreach (m_ts[k]) begin m_ts[k] = 0; m_iss[k] = 0; end
        idle_inputs();
        raddr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R11 reset");
        check_one(12, 0, "R11 unmapped");

        repeat (3) begin gen = 1; cycle(); end
        check_one(0, 3, "R1");

        iss = 1; itag = 1; cycle();
        repeat (4) cycle();
        fil = 1; ftag = 1; fline = 2; cycle();
        check_one(1, 1, "R2");
        check_one(7, 5, "R6 lo");
        check_one(8, 0, "R6 hi");

        hit = 1; hline = 2; cycle();
        check_one(2, 1, "R3 first hit");
        hit = 1; hline = 2; cycle();
        check_one(2, 1, "R3 repeat hit");

        iss = 1; itag = 2; cycle();
        fil = 1; ftag = 2; fline = 3; cycle();
        evc = 1; eline = 3; cycle();
        check_one(3, 1, "R4 marked evict");
        evc = 1; eline = 5; cycle();
        hit = 1; hline = 5; cycle();
        check_one(3, 1, "R4 unmarked evict");
        check_one(2, 1, "R4 unmarked hit");
        check_one(7, 6, "R6 sum");

        lat = 1; can = 1; ovf = 1; cycle();
        can = 1; ovf = 1; cycle();
        ovf = 1; cycle();
        check_one(4, 1, "R5 late");
        check_one(5, 2, "R5 cancel");
        check_one(6, 3, "R5 overflow");

        iss = 1; itag = 0; cycle();
        fil = 1; ftag = 0; fline = 4; cycle();
        hit = 1; hline = 4; evc = 1; eline = 4; cycle();
        check_one(2, 2, "R10 useful");
        check_one(3, 1, "R10 unuseful");

        clr = 1; gen = 1; lat = 1; cycle();
        check_all("R9");
        check_one(0, 0, "R9 clear wins");

        repeat (70) begin gen = 1; cycle(); end
        check_one(0, 63, "R7");
        gen = 1; cycle();
        check_one(0, 63, "R7 hold");

        repeat (5) begin
            iss = 1; itag = 3; cycle();
            repeat (249) cycle();
            fil = 1; ftag = 3; fline = 7; cycle();
        end
        check_one(7, 63, "R8 lo");
        check_one(8, 15, "R8 hi");
        check_all("R8 model");

        clr = 1; cycle();
        for (int i = 0; i < 4000; i++) begin
            gen = ($urandom % 4) == 0;
            lat = ($urandom % 6) == 0;
            can = ($urandom % 6) == 0;
            ovf = ($urandom % 6) == 0;
            iss = ($urandom % 3) == 0;
            itag = 2'($urandom);
            ftag = 2'($urandom);
            fil = (($urandom % 3) == 0) && m_iss[ftag];
            fline = 4'($urandom);
            hit = ($urandom % 2) == 0;
            hline = 4'($urandom);
            evc = ($urandom % 3) == 0;
            eline = (($urandom % 4) == 0) ? hline : 4'($urandom);
            clr = ($urandom % 60) == 0;
            cycle();
            if (i % 4 == 3) check_all("R1-random R3-random R4-random");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule